// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two up-counting timer/counter units for a small microcontroller. Each unit keeps its count in a low byte and a high byte. A 4-bit configuration nibble per unit holds a gate-enable bit, a source select bit and a two-bit mode. One shared control register carries the two run bits and the two sticky overflow flags.

Each unit advances on one of two sources. In timer mode it uses an internal machine-cycle strobe, which fires once every `CLK_PER_CYCLE` clocks. In counter mode it counts falling edges of its external count pin, and that pin is sampled once per machine cycle. Four modes are available:
- a 13-bit counter, in which the low byte's bottom five bits act as a prescaler;
- a plain 16-bit counter;
- an 8-bit counter with automatic reload from the high byte;
- a split mode, in which unit 0 becomes two independent 8-bit counters. The second of these borrows unit 1's run bit and overflow flag.

Software reaches the registers through a single-cycle write strobe and a combinational read port. The interrupt logic reads the flags directly and returns a clear pulse when it accepts an interrupt.

Top module: `twin_timer_counter`

## Requirements
- R1: After reset, every register reads 0 and both flags are low. Register map on `bus_addr`: 0 = unit 0 low, 1 = unit 0 high, 2 = unit 1 low, 3 = unit 1 high, 4 = configuration, 5 = control. In the configuration byte, bits [3:0] belong to unit 0 and bits [7:4] to unit 1. Each nibble is {gate, source select (1 = external pin), mode[1:0]}. In the control byte, bit0 = run0, bit1 = run1, bit2 = flag0, bit3 = flag1.
- R2: In timer mode with mode 01, a running unit adds exactly one to its 16-bit {high, low} value per machine cycle (one cycle per `CLK_PER_CYCLE` clocks), carrying from low to high. Passing from FFFFh to 0000h sets its flag.
- R3: In mode 00, {high, low[4:0]} forms a 13-bit counter. Low[7:5] keep their value. Passing from all ones to zero sets the flag.
- R4: In mode 10, only the low byte counts. When it passes FFh, it is loaded from the high byte instead of 00h and the flag is set. The high byte does not change.
- R5: A unit advances only if its run bit is 1 and either its gate bit is 0 or its `gate_pin` input is high.
- R6: In counter mode, a unit advances once for each high-to-low change between two consecutive machine-cycle samples of its `ext_cnt` pin.
- R7: With unit 0 in mode 11, its low byte counts under run0 and gate0 and sets flag0. Its high byte counts machine cycles whenever run1 is 1 and sets flag1 when it passes FFh.
- R8: While unit 0 is in mode 11, overflows of unit 1 do not set flag1.
- R9: A unit in mode 11 other than unit 0 holds its count.
- R10: A bus write to a count byte takes effect at the next clock edge and wins over any increment in that cycle.
- R11: A flag stays set until a pulse on its `ovf_ack` bit or a control write with that flag bit at 0 clears it. Writing 1 to a flag bit leaves the flag unchanged. An overflow in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ext_cnt | input | 2 | External count pins, one per unit |
| gate_pin | input | 2 | Gate-enable pins, one per unit |
| ovf_ack | input | 2 | Flag clear pulses from the interrupt logic |
| ovf_flag | output | 2 | Overflow flags, one per unit |

## Verification
The bench builds the block with `CLK_PER_CYCLE` set to 3 instead of 12. This makes runs of several hundred machine cycles short enough to wrap the 8-bit and 13-bit counters and to reach full 16-bit rollover from loaded values near the top.

The bench opens each counting window with the gate pin or the run bit for an exact multiple of the machine-cycle period. Every window therefore contains a known number of ticks whatever the strobe's phase, and expected counts follow from a per-tick model of each mode.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int BYTE_W = 8;
  localparam int PRE_W  = 5;
  localparam int ADDR_W = 3;
  localparam int UNITS  = 2;

  typedef enum logic [1:0] {
    M_13BIT  = 2'b00,
    M_16BIT  = 2'b01,
    M_RELOAD = 2'b10,
    M_SPLIT  = 2'b11
  } tc_mode_e;

  typedef struct packed {
    logic     gate;
    logic     ext_sel;
    tc_mode_e mode;
  } tc_cfg_t;

  typedef struct packed {
    logic [BYTE_W-1:0] hi;
    logic [BYTE_W-1:0] lo;
    logic              wrap;
  } tc_step_t;

  localparam logic [ADDR_W-1:0] A_LO0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd5;

  // 13-bit count: high byte over the low byte's prescaler bits
  function automatic tc_step_t step_13(input logic [BYTE_W-1:0] lo,
                                       input logic [BYTE_W-1:0] hi);
    tc_step_t r;
    logic [BYTE_W+PRE_W-1:0] v;
    v      = {hi, lo[PRE_W-1:0]};
    r.wrap = &v;
    v      = v + 1'b1;
    r.hi   = v[BYTE_W+PRE_W-1:PRE_W];
    r.lo   = {lo[BYTE_W-1:PRE_W], v[PRE_W-1:0]};
    return r;
  endfunction

  function automatic tc_step_t step_16(input logic [BYTE_W-1:0] lo,
                                       input logic [BYTE_W-1:0] hi);
    tc_step_t r;
    logic [2*BYTE_W-1:0] v;
    v      = {hi, lo};
    r.wrap = &v;
    v      = v + 1'b1;
    r.hi   = v[2*BYTE_W-1:BYTE_W];
    r.lo   = v[BYTE_W-1:0];
    return r;
  endfunction

  function automatic tc_step_t step_reload(input logic [BYTE_W-1:0] lo,
                                           input logic [BYTE_W-1:0] hi);
    tc_step_t r;
    r.wrap = &lo;
    r.hi   = hi;
    r.lo   = r.wrap ? hi : lo + 1'b1;
    return r;
  endfunction

  // {wrap, value+1} for a single byte
  function automatic logic [BYTE_W:0] inc_byte(input logic [BYTE_W-1:0] b);
    return {&b, b + 1'b1};
  endfunction
endpackage

// File: rtl/tc_tick.sv
module tc_tick
  import tc_pkg::*;
#(
  parameter int CLK_PER_CYCLE = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [UNITS-1:0] ext_pin,
  output logic             mc_tick,
  output logic [UNITS-1:0] ext_fall
);
  localparam int CW = (CLK_PER_CYCLE > 1) ? $clog2(CLK_PER_CYCLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_CYCLE - 1);

  logic [CW-1:0] div_q;

  assign mc_tick = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       div_q <= '0;
    else if (mc_tick) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_samp
    logic samp_q;
    always_ff @(posedge clk) begin
      if (!rst_n)       samp_q <= 1'b0;
      else if (mc_tick) samp_q <= ext_pin[u];
    end
    assign ext_fall[u] = mc_tick & samp_q & ~ext_pin[u];
  end
endmodule

// File: rtl/tc_unit.sv
module tc_unit
  import tc_pkg::*;
#(
  parameter bit HAS_SPLIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tc_cfg_t           cfg,
  input  logic              adv,
  input  logic              split_adv,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              wrap_main,
  output logic              wrap_split
);
  tc_step_t          nxt;
  logic              split_w;
  logic [BYTE_W:0]   t_lo;
  logic [BYTE_W:0]   t_hi;

  assign t_lo = inc_byte(lo_q);
  assign t_hi = inc_byte(hi_q);

  always_comb begin
    nxt     = '{hi: hi_q, lo: lo_q, wrap: 1'b0};
    split_w = 1'b0;
    case (cfg.mode)
      M_13BIT:  if (adv) nxt = step_13(lo_q, hi_q);
      M_16BIT:  if (adv) nxt = step_16(lo_q, hi_q);
      M_RELOAD: if (adv) nxt = step_reload(lo_q, hi_q);
      default: begin
        if (HAS_SPLIT) begin
          if (adv) begin
            nxt.lo   = t_lo[BYTE_W-1:0];
            nxt.wrap = t_lo[BYTE_W];
          end
          if (split_adv) begin
            nxt.hi  = t_hi[BYTE_W-1:0];
            split_w = t_hi[BYTE_W];
          end
        end
      end
    endcase
  end

  // a byte write replaces the step and cancels the overflow it carried
  assign wrap_main  = nxt.wrap &
                      ~((cfg.mode == M_SPLIT) ? wr_lo : (wr_lo | wr_hi));
  assign wrap_split = split_w & ~wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo ? wdata : nxt.lo;
      hi_q <= wr_hi ? wdata : nxt.hi;
    end
  end
endmodule

// File: rtl/tc_regs.sv
module tc_regs
  import tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [BYTE_W-1:0] lo0,
  input  logic [BYTE_W-1:0] hi0,
  input  logic [BYTE_W-1:0] lo1,
  input  logic [BYTE_W-1:0] hi1,
  input  logic [UNITS-1:0]  ovf_set,
  input  logic [UNITS-1:0]  ovf_ack,
  output tc_cfg_t           cfg0,
  output tc_cfg_t           cfg1,
  output logic [UNITS-1:0]  run,
  output logic [UNITS-1:0]  flag,
  output logic [UNITS-1:0]  wr_lo,
  output logic [UNITS-1:0]  wr_hi,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] cfg_q;
  logic              ctl_we;
  logic [UNITS-1:0]  keep;

  assign wr_lo[0] = bus_we && bus_addr == A_LO0;
  assign wr_hi[0] = bus_we && bus_addr == A_HI0;
  assign wr_lo[1] = bus_we && bus_addr == A_LO1;
  assign wr_hi[1] = bus_we && bus_addr == A_HI1;
  assign ctl_we   = bus_we && bus_addr == A_CTRL;

  assign cfg0 = tc_cfg_t'(cfg_q[3:0]);
  assign cfg1 = tc_cfg_t'(cfg_q[7:4]);

  assign keep = ctl_we ? bus_wdata[3:2] : {UNITS{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      run   <= '0;
      flag  <= '0;
    end else begin
      if (bus_we && bus_addr == A_CFG) cfg_q <= bus_wdata;
      if (ctl_we) run <= bus_wdata[1:0];
      flag <= (flag & keep & ~ovf_ack) | ovf_set;
    end
  end

  always_comb begin
    case (bus_addr)
      A_LO0:   rdata = lo0;
      A_HI0:   rdata = hi0;
      A_LO1:   rdata = lo1;
      A_HI1:   rdata = hi1;
      A_CFG:   rdata = cfg_q;
      A_CTRL:  rdata = {4'b0, flag, run};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/twin_timer_counter.sv
module twin_timer_counter
  import tc_pkg::*;
#(
  parameter int CLK_PER_CYCLE = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [1:0]  ext_cnt,
  input  logic [1:0]  gate_pin,
  input  logic [1:0]  ovf_ack,
  output logic [1:0]  ovf_flag
);
  logic              mc_tick;
  logic [UNITS-1:0]  ext_fall;
  tc_cfg_t           cfg [UNITS];
  logic [UNITS-1:0]  run, wr_lo, wr_hi, adv, wrap_main, wrap_split, ovf_set;
  logic [BYTE_W-1:0] lo [UNITS];
  logic [BYTE_W-1:0] hi [UNITS];
  logic              split_mode;
  logic              split_adv;
  logic [1:0]        mode1;

  tc_tick #(.CLK_PER_CYCLE(CLK_PER_CYCLE)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_cnt),
    .mc_tick(mc_tick), .ext_fall(ext_fall)
  );

  tc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .lo0(lo[0]), .hi0(hi[0]), .lo1(lo[1]), .hi1(hi[1]),
    .ovf_set(ovf_set), .ovf_ack(ovf_ack), .cfg0(cfg[0]), .cfg1(cfg[1]),
    .run(run), .flag(ovf_flag), .wr_lo(wr_lo), .wr_hi(wr_hi), .rdata(bus_rdata)
  );

  assign split_mode = (cfg[0].mode == M_SPLIT);
  assign split_adv  = mc_tick & run[1];
  assign mode1      = cfg[1].mode;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign adv[u] = run[u] & (~cfg[u].gate | gate_pin[u]) &
                    (cfg[u].ext_sel ? ext_fall[u] : mc_tick);

    tc_unit #(.HAS_SPLIT(u == 0)) u_unit (
      .clk(clk), .rst_n(rst_n), .cfg(cfg[u]), .adv(adv[u]),
      .split_adv((u == 0) ? split_adv : 1'b0),
      .wr_lo(wr_lo[u]), .wr_hi(wr_hi[u]), .wdata(bus_wdata),
      .lo_q(lo[u]), .hi_q(hi[u]),
      .wrap_main(wrap_main[u]), .wrap_split(wrap_split[u])
    );
  end

  assign ovf_set[0] = wrap_main[0];
  assign ovf_set[1] = split_mode ? wrap_split[0] : wrap_main[1];
endmodule

// File: rtl/twin_timer_counter_chk.sv
module twin_timer_counter_chk #(
  parameter int CLK_PER_CYCLE = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mc_tick,
  input logic [1:0] ovf_set,
  input logic [1:0] ovf_flag,
  input logic [1:0] ovf_ack,
  input logic [1:0] run,
  input logic [1:0] wr_lo,
  input logic [1:0] wr_hi,
  input logic       split_mode,
  input logic [1:0] mode1,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1
);
  // R11
  flag0_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag[0]) |-> $past(ovf_set[0]));
  // R11
  flag1_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag[1]) |-> $past(ovf_set[1]));
  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ack[0] && !ovf_set[0]) |=> !ovf_flag[0]);
  // R9
  unit1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode1 == 2'b11 && !wr_lo[1] && !wr_hi[1]) |=> $stable({hi1, lo1}));
  // R2
  idle_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_tick && wr_lo == 2'b00 && wr_hi == 2'b00) |=> $stable({hi0, lo0, hi1, lo1}));
  // R5
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !wr_lo[0]) |=> $stable(lo0));
  // R8
  split_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split_mode && !run[1]) |=> !$rose(ovf_flag[1]));

  if (CLK_PER_CYCLE > 1) begin : g_gap
    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mc_tick |=> !mc_tick);
  end
endmodule

bind twin_timer_counter twin_timer_counter_chk #(.CLK_PER_CYCLE(CLK_PER_CYCLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ovf_set(ovf_set),
  .ovf_flag(ovf_flag), .ovf_ack(ovf_ack), .run(run), .wr_lo(wr_lo),
  .wr_hi(wr_hi), .split_mode(split_mode), .mode1(mode1),
  .lo0(lo[0]), .hi0(hi[0]), .lo1(lo[1]), .hi1(hi[1])
);

// File: tb/twin_timer_counter_bench.sv
module twin_timer_counter_bench;
  localparam int D = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] ext_cnt = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] ovf_ack = '0;
  logic [1:0] ovf_flag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  twin_timer_counter #(.CLK_PER_CYCLE(D)) u_twin_timer_counter (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_cnt(ext_cnt),
    .gate_pin(gate_pin), .ovf_ack(ovf_ack), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic gated_run(input int u, input int k);
    gate_pin[u] = 1'b1;
    repeat (k * D) @(negedge clk);
    gate_pin[u] = 1'b0;
  endtask

  task automatic run_bits(input logic [1:0] r, input int k);
    wr(3'd5, {4'b0000, 2'b11, r});
    repeat (k * D - 1) @(negedge clk);
    wr(3'd5, 8'h0C);
  endtask

  // per-tick model of modes 00, 01, 10: returns {flag, hi, lo}
  function automatic logic [16:0] model(input int m, input logic [7:0] lo,
                                        input logic [7:0] hi, input int n);
    logic f = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (m == 0) begin
        if (lo[4:0] == 5'h1F) begin
          lo[4:0] = 5'h00;
          if (hi == 8'hFF) f = 1'b1;
          hi = hi + 8'd1;
        end else lo[4:0] = lo[4:0] + 5'd1;
      end else if (m == 1) begin
        if (lo == 8'hFF) begin
          if (hi == 8'hFF) f = 1'b1;
          hi = hi + 8'd1;
        end
        lo = lo + 8'd1;
      end else begin
        if (lo == 8'hFF) begin lo = hi; f = 1'b1; end
        else lo = lo + 8'd1;
      end
    end
    return {f, hi, lo};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, lo, hi;
    logic [16:0] e;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 0);
    end
    chk("R1 reset flags", ovf_flag, 0);

    // R2 one step per machine cycle, carry low->high
    wr(3'd4, 8'h09);
    wr(3'd0, 8'hFE); wr(3'd1, 8'h00);
    wr(3'd5, 8'h01);
    gated_run(0, 3);
    rd(3'd0, lo); rd(3'd1, hi);
    chk("R2 16-bit carry", {hi, lo}, 16'h0101);
    chk("R2 no flag", ovf_flag, 0);

    // R5 gate pin low: no advance
    repeat (10 * D) @(negedge clk);
    rd(3'd0, lo);
    chk("R5 gate low holds", lo, 8'h01);
    // R5 run bit off with gate pin high: no advance
    wr(3'd5, 8'h00);
    gated_run(0, 6);
    rd(3'd0, lo);
    chk("R5 run off holds", lo, 8'h01);
    // R5 gate bit 0 ignores the pin
    wr(3'd4, 8'h01);
    run_bits(2'b01, 4);
    rd(3'd0, lo);
    chk("R5 gate bit 0 counts", lo, 8'h05);

    // R3 13-bit mode
    wr(3'd4, 8'h08);
    wr(3'd0, 8'hBE); wr(3'd1, 8'hFF);
    wr(3'd5, 8'h01);
    gated_run(0, 3);
    rd(3'd0, lo); rd(3'd1, hi);
    chk("R3 low byte", lo, 8'hA1);
    chk("R3 high byte", hi, 8'h00);
    chk("R3 flag", ovf_flag[0], 1);

    // R11 control write with flag bit 0 clears, with 1 keeps
    wr(3'd5, 8'h05);
    chk("R11 write 1 keeps", ovf_flag[0], 1);
    wr(3'd5, 8'h01);
    chk("R11 write 0 clears", ovf_flag[0], 0);

    // R4 reload
    wr(3'd4, 8'h0A);
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFC);
    gated_run(0, 5);
    rd(3'd0, lo); rd(3'd1, hi);
    chk("R4 reloaded low", lo, 8'hFF);
    chk("R4 high unchanged", hi, 8'hFC);
    chk("R4 flag", ovf_flag[0], 1);

    // R10 write wins over increment
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h01);
    wr(3'd5, 8'h01);
    repeat (5) @(negedge clk);
    wr(3'd0, 8'h77);
    rd(3'd0, lo);
    chk("R10 write override", lo, 8'h77);
    wr(3'd5, 8'h00);

    // R6 counter mode on unit 1
    wr(3'd4, 8'h50);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd5, 8'h02);
    for (int p = 0; p < 5; p++) begin
      ext_cnt[1] = 1'b1; repeat (2 * D) @(negedge clk);
      ext_cnt[1] = 1'b0; repeat (2 * D) @(negedge clk);
    end
    repeat (4 * D) @(negedge clk);
    wr(3'd5, 8'h0C);
    rd(3'd2, lo); rd(3'd3, hi);
    chk("R6 falling edges counted", {hi, lo}, 16'h0005);

    // R7 split mode, R8 unit 1 overflow masked
    wr(3'd4, 8'h13);
    wr(3'd0, 8'h10); wr(3'd1, 8'hFE);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd5, 8'h00);
    run_bits(2'b10, 3);
    rd(3'd0, lo); rd(3'd1, hi);
    chk("R7 split high", hi, 8'h01);
    chk("R7 split low held by run0", lo, 8'h10);
    chk("R7 flag1 from split high", ovf_flag, 2'b10);
    rd(3'd2, lo);
    chk("R7 unit1 still runs", lo, 8'h02);
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    run_bits(2'b10, 2);
    rd(3'd2, lo); rd(3'd3, hi);
    chk("R8 unit1 wrapped", {hi, lo}, 16'h0001);
    chk("R8 flag1 not set", ovf_flag[1], 0);

    // R11 ack pulse clears flag
    wr(3'd1, 8'hFF);
    run_bits(2'b10, 1);
    chk("R11 flag set before ack", ovf_flag[1], 1);
    ovf_ack[1] = 1'b1; @(negedge clk); ovf_ack[1] = 1'b0;
    chk("R11 ack clears", ovf_flag[1], 0);

    // R9 unit 1 in mode 11 holds
    wr(3'd4, 8'h30);
    wr(3'd2, 8'h55); wr(3'd3, 8'hAA);
    run_bits(2'b10, 10);
    rd(3'd2, lo); rd(3'd3, hi);
    chk("R9 unit1 hold", {hi, lo}, 16'hAA55);

    // R2/R3/R4 random against model
    for (int i = 0; i < 24; i++) begin
      int u, m, k;
      logic [3:0] nib;
      u = int'($urandom_range(0, 1));
      m = int'($urandom_range(0, 2));
      k = int'($urandom_range(1, 400));
      lo = 8'($urandom); hi = 8'($urandom);
      if (i % 3 == 0) hi = 8'hFF;
      nib = {1'b1, 1'b0, 2'(m)};
      wr(3'd4, (u == 1) ? {nib, 4'h0} : {4'h0, nib});
      wr(3'(2 * u), lo); wr(3'(2 * u + 1), hi);
      wr(3'd5, (u == 1) ? 8'h02 : 8'h01);
      gated_run(u, k);
      e = model(m, lo, hi, k);
      rd(3'(2 * u), lo); rd(3'(2 * u + 1), hi);
      chk("R2 R3 R4 random count", {hi, lo}, e[15:0]);
      chk("R2 R3 R4 random flag", ovf_flag[u], e[16]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule